// File: doc/BRIEF.md
# Internal Data Memory Address Unit

This block owns the 256-byte on-chip data store of an 8-bit controller core. It turns each memory request into a byte location, using one of four access kinds. A register access selects one of eight working registers in the active bank. A direct access uses the byte address as given, and any direct address in the upper half goes to the special-function-register (SFR) bus. An indirect access always reaches RAM, including the upper 128 bytes. A bit access reaches a single bit, either in a 16-byte window of RAM or in an SFR.

The block also holds the stack pointer and runs push and pop commands against the same RAM. The core issues at most one request per cycle. Read results come back one cycle later on a single result port. The SFRs sit outside this block and answer combinationally on the SFR bus.

Top module: `dmem_addr_unit`

## Requirements
- R1: After reset the stack pointer reads 07H, the read result reads 00H and every RAM byte holds 00H.
- R2: A register request (kind code 0) reaches RAM byte bank×8 + n. Here bank is the 2-bit bank select and n is bits [2:0] of the request address. The upper address bits are ignored.
- R3: Direct requests (kind code 1) and indirect requests (kind code 2) to addresses 00H–7FH reach the same RAM bytes.
- R4: A direct request to 80H–FFH raises the SFR read strobe (for a read) or the SFR write strobe (for a write) in the same cycle, with the SFR address equal to the request address. A direct read returns the SFR data, and RAM is left unchanged.
- R5: An indirect request to 80H–FFH reaches the upper 128 RAM bytes and never raises an SFR strobe.
- R6: A bit request (kind code 3) with bit address b below 80H reaches bit b mod 8 of RAM byte 20H + b/8. A bit read returns that bit in bit 0, with zeros above it. A bit write stores bit 0 of the write data into that bit and leaves the other seven bits unchanged.
- R7: A bit request with bit address 80H–FFH reaches the SFR at the bit address with its low three bits cleared. A bit write raises both SFR strobes in the same cycle and drives the SFR byte just read, with only the addressed bit replaced.
- R8: A read result appears on the cycle after the request and holds until the next read or pop. A read issued right after a write to the same location returns the new value.
- R9: A push command (stack code 1) first increments the stack pointer and then writes the push data at the new pointer, so the first push after reset lands at 08H. The stack pointer changes only on push or pop, and it wraps modulo 256.
- R10: A pop command (stack code 2) returns the byte at the current stack pointer on the next cycle and decrements the stack pointer.
- R11: A push or pop takes the cycle. A memory request issued in the same cycle is dropped: it causes no RAM write, no SFR strobe and no read result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Memory request present this cycle |
| req_kind | input | 2 | Access kind: 0 register, 1 direct, 2 indirect, 3 bit |
| req_addr | input | 8 | Byte address, register number or bit address |
| req_wdata | input | 8 | Write data (bit 0 only for bit writes) |
| req_we | input | 1 | Request is a write |
| bank_sel | input | 2 | Active register bank |
| stk_op | input | 2 | Stack command: 1 push, 2 pop, 0 or 3 none |
| stk_wdata | input | 8 | Byte to push |
| rd_data | output | 8 | Registered read or pop result |
| sp | output | 8 | Current stack pointer |
| sfr_addr | output | 8 | SFR byte address |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, combinational |

## Verification
Some properties are checked by assertions on every cycle:
- the SFR strobes fire only for upper-half direct or bit requests outside stack cycles;
- an SFR bit write reads and writes in the same cycle, at an aligned byte, changing at most one bit;
- push and pop step the stack pointer by exactly one, and it holds otherwise;
- the read result holds when no read or pop is issued.

Only the bench's scenarios can show where data actually lands, because the assertions cannot see stored contents. These cover bank mapping, the aliasing of direct and indirect access in the lower half, the split of the upper half between RAM and SFRs, bit placement across the 20H–2FH window and read-after-write. A reference model checks all of these against a long mixed stream.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
    localparam int DW        = 8;
    localparam int AW        = 8;
    localparam int BANK_W    = 2;
    localparam int REG_IDX_W = 3;
    localparam int BIT_IDX_W = $clog2(DW);
    localparam int DEPTH     = 1 << AW;
    localparam logic [AW-1:0] BIT_BASE = 8'h20;

    typedef enum logic [1:0] {
        ACC_REG = 2'd0,
        ACC_DIR = 2'd1,
        ACC_IND = 2'd2,
        ACC_BIT = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        STK_NONE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_RSVD = 2'd3
    } stk_op_e;

    typedef struct packed {
        logic                 to_sfr;
        logic                 is_bit;
        logic [AW-1:0]        byte_addr;
        logic [BIT_IDX_W-1:0] bit_idx;
    } target_t;

    function automatic logic [DW-1:0] put_bit(input logic [DW-1:0] v,
                                              input logic [BIT_IDX_W-1:0] idx,
                                              input logic b);
        logic [DW-1:0] r;
        r      = v;
        r[idx] = b;
        return r;
    endfunction
endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
    import dmem_pkg::*;
(
    input  logic [1:0]        kind,
    input  logic [AW-1:0]     addr,
    input  logic [BANK_W-1:0] bank,
    output target_t           tgt
);
    always_comb begin
        tgt           = '0;
        tgt.byte_addr = addr;
        case (acc_kind_e'(kind))
            ACC_REG: tgt.byte_addr = AW'({bank, addr[REG_IDX_W-1:0]});
            ACC_DIR: tgt.to_sfr    = addr[AW-1];
            ACC_IND: tgt.to_sfr    = 1'b0;
            ACC_BIT: begin
                tgt.is_bit  = 1'b1;
                tgt.bit_idx = addr[BIT_IDX_W-1:0];
                if (addr[AW-1]) begin
                    tgt.to_sfr    = 1'b1;
                    tgt.byte_addr = {addr[AW-1:BIT_IDX_W], {BIT_IDX_W{1'b0}}};
                end else begin
                    tgt.byte_addr = BIT_BASE + AW'(addr[AW-2:BIT_IDX_W]);
                end
            end
            default: tgt.to_sfr = 1'b0;
        endcase
    end
endmodule

// File: rtl/dmem_stack.sv
module dmem_stack
    import dmem_pkg::*;
#(
    parameter logic [AW-1:0] SP_INIT = 8'h07
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] sp,
    output logic [AW-1:0] sp_inc
);
    typedef struct packed {
        logic [AW-1:0] sp;
    } stk_state_t;

    stk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push)
            st_d.sp = st_q.sp + AW'(1);
        else if (pop)
            st_d.sp = st_q.sp - AW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '{sp: SP_INIT};
        else
            st_q <= st_d;
    end

    assign sp     = st_q.sp;
    assign sp_inc = st_q.sp + AW'(1);
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram
    import dmem_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] rows [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        logic [DW-1:0] row_d, row_q;

        always_comb begin
            row_d = row_q;
            if (we && waddr == AW'(i))
                row_d = wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                row_q <= '0;
            else
                row_q <= row_d;
        end

        assign rows[i] = row_q;
    end

    assign rdata = rows[raddr];
endmodule

// File: rtl/dmem_addr_unit.sv
module dmem_addr_unit
    import dmem_pkg::*;
#(
    parameter logic [AW-1:0] SP_INIT = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic              req_we,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [1:0]        stk_op,
    input  logic [DW-1:0]     stk_wdata,
    output logic [DW-1:0]     rd_data,
    output logic [AW-1:0]     sp,
    output logic [AW-1:0]     sfr_addr,
    output logic              sfr_rd,
    output logic              sfr_wr,
    output logic [DW-1:0]     sfr_wdata,
    input  logic [DW-1:0]     sfr_rdata
);
    typedef struct packed {
        logic [DW-1:0] rd_data;
    } top_state_t;

    top_state_t    st_d, st_q;
    target_t       tgt;
    logic          do_push, do_pop, req_go;
    logic [AW-1:0] sp_q, sp_inc;
    logic          ram_we;
    logic [AW-1:0] ram_waddr, ram_raddr;
    logic [DW-1:0] ram_wdata, ram_rdata;
    logic [DW-1:0] src_byte;

    dmem_decode u_dec (
        .kind (req_kind),
        .addr (req_addr),
        .bank (bank_sel),
        .tgt  (tgt)
    );

    assign do_push = stk_op_e'(stk_op) == STK_PUSH;
    assign do_pop  = stk_op_e'(stk_op) == STK_POP;
    assign req_go  = req_valid && !do_push && !do_pop;

    dmem_stack #(.SP_INIT(SP_INIT)) u_stk (
        .clk    (clk),
        .rst_n  (rst_n),
        .push   (do_push),
        .pop    (do_pop),
        .sp     (sp_q),
        .sp_inc (sp_inc)
    );

    dmem_ram u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    always_comb begin
        ram_raddr = do_pop ? sp_q : tgt.byte_addr;
        ram_we    = do_push || (req_go && req_we && !tgt.to_sfr);
        ram_waddr = do_push ? sp_inc : tgt.byte_addr;
        if (do_push)
            ram_wdata = stk_wdata;
        else if (tgt.is_bit)
            ram_wdata = put_bit(ram_rdata, tgt.bit_idx, req_wdata[0]);
        else
            ram_wdata = req_wdata;

        sfr_rd    = req_go && tgt.to_sfr && (!req_we || tgt.is_bit);
        sfr_wr    = req_go && tgt.to_sfr && req_we;
        sfr_addr  = (req_go && tgt.to_sfr) ? tgt.byte_addr : '0;
        sfr_wdata = '0;
        if (sfr_wr)
            sfr_wdata = tgt.is_bit ? put_bit(sfr_rdata, tgt.bit_idx, req_wdata[0])
                                   : req_wdata;
    end

    always_comb begin
        st_d     = st_q;
        src_byte = tgt.to_sfr ? sfr_rdata : ram_rdata;
        if (do_pop)
            st_d.rd_data = ram_rdata;
        else if (req_go && !req_we)
            st_d.rd_data = tgt.is_bit ? DW'(src_byte[tgt.bit_idx]) : src_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_data = st_q.rd_data;
    assign sp      = sp_q;
endmodule

// File: rtl/dmem_addr_unit_chk.sv
module dmem_addr_unit_chk
    import dmem_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_kind,
    input logic [AW-1:0] req_addr,
    input logic          req_we,
    input logic [1:0]    stk_op,
    input logic [DW-1:0] rd_data,
    input logic [AW-1:0] sp,
    input logic [AW-1:0] sfr_addr,
    input logic          sfr_rd,
    input logic          sfr_wr,
    input logic [DW-1:0] sfr_wdata,
    input logic [DW-1:0] sfr_rdata
);
    logic stk_busy, rd_issue;
    assign stk_busy = (stk_op == STK_PUSH) || (stk_op == STK_POP);
    assign rd_issue = (stk_op == STK_POP) || (req_valid && !req_we && !stk_busy);

    // R4: strobes only for upper-half direct or bit requests
    p_sfr_upper_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd || sfr_wr) |-> (req_valid && req_addr[AW-1] &&
                                (req_kind == ACC_DIR || req_kind == ACC_BIT)));

    // R5: indirect never reaches the SFR bus
    p_ind_no_sfr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == ACC_IND) |-> (!sfr_rd && !sfr_wr));

    // R7: SFR bit access aligned, read and write together, one bit changed
    p_bit_sfr_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_rd && req_kind == ACC_BIT) |-> (sfr_addr[BIT_IDX_W-1:0] == '0));
    p_bit_sfr_onebit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && req_kind == ACC_BIT) |-> (sfr_rd && $countones(sfr_wdata ^ sfr_rdata) <= 1));

    // R8: result holds without a read or pop
    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_issue |=> $stable(rd_data));

    // R9: push increments, pointer otherwise steady
    p_push_inc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_op == STK_PUSH) |=> (sp == $past(sp) + AW'(1)));
    p_sp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !stk_busy |=> $stable(sp));

    // R10: pop decrements
    p_pop_dec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_op == STK_POP) |=> (sp == $past(sp) - AW'(1)));

    // R11: stack cycle blocks the SFR bus
    p_stack_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stk_busy |-> (!sfr_rd && !sfr_wr));
endmodule

bind dmem_addr_unit dmem_addr_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_addr  (req_addr),
    .req_we    (req_we),
    .stk_op    (stk_op),
    .rd_data   (rd_data),
    .sp        (sp),
    .sfr_addr  (sfr_addr),
    .sfr_rd    (sfr_rd),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .sfr_rdata (sfr_rdata)
);

// File: tb/dmem_addr_unit_bench.sv
`timescale 1ns/1ps
module dmem_addr_unit_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [7:0] req_addr = 8'd0;
    logic [7:0] req_wdata = 8'd0;
    logic       req_we = 1'b0;
    logic [1:0] bank_sel = 2'd0;
    logic [1:0] stk_op = 2'd0;
    logic [7:0] stk_wdata = 8'd0;
    logic [7:0] rd_data, sp, sfr_addr, sfr_wdata, sfr_rdata;
    logic       sfr_rd, sfr_wr;

    logic [7:0] mem_m [256];
    logic [7:0] sfr_m [128];
    logic [7:0] sp_m, rd_m;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    assign sfr_rdata = sfr_m[sfr_addr[6:0]];

    dmem_addr_unit u_dmem_addr_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_we(req_we),
        .bank_sel(bank_sel), .stk_op(stk_op), .stk_wdata(stk_wdata),
        .rd_data(rd_data), .sp(sp), .sfr_addr(sfr_addr), .sfr_rd(sfr_rd),
        .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input string req, input logic [1:0] k, input logic [7:0] a,
                        input logic [7:0] wd, input logic we, input logic v,
                        input logic [1:0] bank, input logic [1:0] sop,
                        input logic [7:0] swd);
        logic push, pop, go, tosfr, isbit, e_rd, e_wr;
        logic [7:0] ba, cur, newv;
        int bi;
        req_kind = k; req_addr = a; req_wdata = wd; req_we = we; req_valid = v;
        bank_sel = bank; stk_op = sop; stk_wdata = swd;
        #1;
        push = (sop == 2'd1);
        pop  = (sop == 2'd2);
        go   = v && !push && !pop;
        tosfr = 0; isbit = 0; bi = 0;
        case (k)
            2'd0: ba = 8'(int'(bank) * 8 + int'(a) % 8);
            2'd1: begin ba = a; tosfr = (a >= 8'h80); end
            2'd2: ba = a;
            default: begin
                isbit = 1; bi = int'(a) % 8;
                if (a >= 8'h80) begin ba = 8'(int'(a) - bi); tosfr = 1; end
                else ba = 8'(32 + int'(a) / 8);
            end
        endcase
        e_rd = go && tosfr && (!we || isbit);
        e_wr = go && tosfr && we;
        chk(req, "sfr_rd", {7'd0, sfr_rd}, {7'd0, e_rd});
        chk(req, "sfr_wr", {7'd0, sfr_wr}, {7'd0, e_wr});
        cur = tosfr ? sfr_m[ba[6:0]] : mem_m[ba];
        newv = cur;
        if (isbit) newv[bi] = wd[0]; else newv = wd;
        if (e_rd || e_wr) chk(req, "sfr_addr", sfr_addr, ba);
        if (e_wr) chk(req, "sfr_wdata", sfr_wdata, newv);
        @(posedge clk);
        #1;
        if (push) begin
            sp_m = sp_m + 8'd1;
            mem_m[sp_m] = swd;
        end else if (pop) begin
            rd_m = mem_m[sp_m];
            sp_m = sp_m - 8'd1;
        end else if (go) begin
            if (we) begin
                if (tosfr) sfr_m[ba[6:0]] = newv; else mem_m[ba] = newv;
            end else begin
                rd_m = isbit ? {7'd0, cur[bi]} : cur;
            end
        end
        @(negedge clk);
        chk(req, "rd_data", rd_data, rd_m);
        chk(req, "sp", sp, sp_m);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
        for (int i = 0; i < 128; i++) sfr_m[i] = 8'(i * 3 + 1);
        sp_m = 8'h07; rd_m = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1", "sp", sp, 8'h07);
        chk("R1", "rd_data", rd_data, 8'h00);
        step("R1", 2'd2, 8'h00, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        step("R1", 2'd2, 8'hFF, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        step("R1", 2'd1, 8'h7F, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        // R2 bank mapping
        for (int b = 0; b < 4; b++)
            step("R2", 2'd0, 8'h05, 8'(8'h50 + b), 1, 1, 2'(b), 2'd0, 8'h00);
        for (int b = 0; b < 4; b++)
            step("R2", 2'd2, 8'(b * 8 + 5), 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        step("R2", 2'd0, 8'hFD, 8'h00, 0, 1, 2'd1, 2'd0, 8'h00);
        // R3 and R8 aliasing, read after write
        step("R3", 2'd1, 8'h30, 8'h3C, 1, 1, 2'd0, 2'd0, 8'h00);
        step("R8", 2'd2, 8'h30, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        step("R8", 2'd0, 8'h00, 8'h00, 0, 0, 2'd0, 2'd0, 8'h00);
        // R4 direct upper to SFR, R5 indirect upper to RAM
        step("R4", 2'd1, 8'h90, 8'h5A, 1, 1, 2'd0, 2'd0, 8'h00);
        step("R4", 2'd1, 8'h90, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        step("R5", 2'd2, 8'h90, 8'hC3, 1, 1, 2'd0, 2'd0, 8'h00);
        step("R5", 2'd2, 8'h90, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        step("R4", 2'd1, 8'h90, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        // R6 RAM bits
        step("R6", 2'd3, 8'h00, 8'h01, 1, 1, 2'd0, 2'd0, 8'h00);
        step("R6", 2'd3, 8'h7F, 8'h01, 1, 1, 2'd0, 2'd0, 8'h00);
        step("R6", 2'd3, 8'h13, 8'hFF, 1, 1, 2'd0, 2'd0, 8'h00);
        step("R6", 2'd2, 8'h20, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        step("R6", 2'd2, 8'h2F, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        step("R6", 2'd2, 8'h22, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        step("R6", 2'd3, 8'h13, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        step("R6", 2'd3, 8'h14, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        step("R6", 2'd2, 8'h25, 8'hF0, 1, 1, 2'd0, 2'd0, 8'h00);
        step("R6", 2'd3, 8'h2C, 8'h00, 1, 1, 2'd0, 2'd0, 8'h00);
        step("R6", 2'd2, 8'h25, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        // R7 SFR bits
        step("R7", 2'd3, 8'h93, 8'h01, 1, 1, 2'd0, 2'd0, 8'h00);
        step("R7", 2'd3, 8'h93, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        step("R7", 2'd1, 8'h90, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        // R9 and R10 stack
        step("R9", 2'd0, 8'h00, 8'h00, 0, 0, 2'd0, 2'd1, 8'h11);
        step("R9", 2'd0, 8'h00, 8'h00, 0, 0, 2'd0, 2'd1, 8'h22);
        step("R9", 2'd2, 8'h08, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        step("R10", 2'd0, 8'h00, 8'h00, 0, 0, 2'd0, 2'd2, 8'h00);
        step("R10", 2'd0, 8'h00, 8'h00, 0, 0, 2'd0, 2'd2, 8'h00);
        // R11 stack precedence
        step("R11", 2'd1, 8'h90, 8'hEE, 1, 1, 2'd0, 2'd1, 8'h33);
        step("R11", 2'd2, 8'h40, 8'h77, 1, 1, 2'd0, 2'd1, 8'h44);
        step("R11", 2'd2, 8'h40, 8'h00, 0, 1, 2'd0, 2'd2, 8'h00);
        step("R11", 2'd2, 8'h40, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        step("R11", 2'd1, 8'h90, 8'h00, 0, 1, 2'd0, 2'd0, 8'h00);
        // mixed stream against the model (R2 to R11)
        for (int i = 0; i < 600; i++) begin
            logic [1:0] sop;
            sop = (($urandom % 8) == 0) ? 2'($urandom % 4) : 2'd0;
            step("R8", 2'($urandom % 4), 8'($urandom), 8'($urandom), 1'($urandom % 2),
                 ($urandom % 4) != 0, 2'($urandom % 4), sop, 8'($urandom));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule